// File: doc/BRIEF.md
# MMU Control Register File

This block is the register bank that a processor core uses to hold its address-translation and exception-event state. It stores nine 32-bit registers: an MMU control word, the high and low halves of a page-table entry, a page-table-entry assist field, a translation-table base, an exception address, a trap code, an exception event code and an interrupt event code. Software reaches them through a simple single-cycle register bus that carries request, write enable, byte offset, access size and write data, and returns read data one cycle later.

Two kinds of write also tell the external translation unit to act. Setting the invalidate bit in the MMU control word requests that the whole TLB be invalidated. Writing the page-table-entry-high register with a new address-space identifier requests a TLB flush. Each request is a one-cycle pulse. The bit that triggers the invalidate is never stored. Several registers keep only a narrow field of what is written to them. An access of the wrong size or to an offset with no register behind it sets a sticky error flag.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset, every register reads 0, `tlb_inval_o` and `tlb_flush_o` are low, `err_o` is low and `rdata_o` is 0.
- R2: An access is legal only when `size_i` is 2 (32-bit; 0 means byte and 1 means half-word) and `addr_i` is word aligned and lies below 0x24. The register at offset 0x00 is the MMU control word, 0x04 is entry-high, 0x08 is entry-low, 0x0C is entry-assist, 0x10 is table base, 0x14 is exception address, 0x18 is trap code, 0x1C is exception event and 0x20 is interrupt event. A legal read puts the register value on `rdata_o` after the next clock edge, and `rdata_o` holds that value until the next read.
- R3: The entry-low, table-base and exception-address registers store all 32 written bits.
- R4: The entry-assist register keeps write bits [3:0]. Its bits [31:4] always read as 0.
- R5: The trap-code, exception-event and interrupt-event registers keep write bits [10:0]. Their bits [31:11] always read as 0.
- R6: A write to the MMU control word with bit 2 set drives `tlb_inval_o` high for exactly the cycle after the write. Bit 2 always reads back as 0. All other bits of the word are stored as written.
- R7: A write to entry-high whose bits [7:0] differ from the held bits [7:0] drives `tlb_flush_o` high for exactly the cycle after the write. A write with equal bits [7:0] raises no flush. In both cases all 32 bits are stored.
- R8: An illegal access sets `err_o` from the next cycle on, and `err_o` stays set until reset. An illegal read returns 0 on `rdata_o`. An illegal write changes no register and raises no pulse.
- R9: Reads never raise a pulse, and one write raises at most one of the two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| size_i | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, registered |
| tlb_inval_o | output | 1 | One-cycle request to invalidate the TLB |
| tlb_flush_o | output | 1 | One-cycle request to flush the TLB after the identifier changes |
| err_o | output | 1 | Sticky flag for an illegal access |

## Verification
The pulse left by one write appears in the same cycle as the bus access that follows it. The bench provokes this with back-to-back writes: an invalidate write is followed at once by an identifier-changing entry-high write, and then by a read. It judges each cycle against a behavioural model. In that sequence the invalidate pulse must line up with the entry-high write, the flush pulse must line up with the read, the two pulses must never overlap, and the data stored by the overlapping accesses must be unaffected.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int NUM_REGS = 9;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [IDX_W-1:0] {
    REG_MMU_CTL    = 4'd0,
    REG_PTE_HI     = 4'd1,
    REG_PTE_LO     = 4'd2,
    REG_PTE_ASSIST = 4'd3,
    REG_TT_BASE    = 4'd4,
    REG_EXC_ADDR   = 4'd5,
    REG_TRAP_CODE  = 4'd6,
    REG_EXC_EVT    = 4'd7,
    REG_INT_EVT    = 4'd8
  } reg_idx_e;
endpackage

// File: rtl/mmu_reg_decode.sv
module mmu_reg_decode
  import mmu_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [ADDR_W-3:0] word_idx;
  assign word_idx = addr_i[ADDR_W-1:2];

  assign hit_o = (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00)
              && (word_idx < (ADDR_W-2)'(NUM_REGS));
  assign idx_o = IDX_W'(word_idx);
endmodule

// File: rtl/mmu_reg_bank.sv
module mmu_reg_bank
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TI_BIT   = 2,
  parameter int ASSIST_W = 4,
  parameter int EVT_W    = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] regs_o [NUM_REGS]
);
  localparam logic [DATA_W-1:0] ALL_MASK    = '1;
  localparam logic [DATA_W-1:0] CTL_MASK    = ~(DATA_W'(1) << TI_BIT);
  localparam logic [DATA_W-1:0] ASSIST_MASK = {{(DATA_W-ASSIST_W){1'b0}}, {ASSIST_W{1'b1}}};
  localparam logic [DATA_W-1:0] EVT_MASK    = {{(DATA_W-EVT_W){1'b0}}, {EVT_W{1'b1}}};

  function automatic logic [DATA_W-1:0] keep_mask(int i);
    case (i)
      int'(REG_MMU_CTL):    return CTL_MASK;
      int'(REG_PTE_ASSIST): return ASSIST_MASK;
      int'(REG_TRAP_CODE),
      int'(REG_EXC_EVT),
      int'(REG_INT_EVT):    return EVT_MASK;
      default:              return ALL_MASK;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] MASK = keep_mask(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_o[g] <= '0;
      else if (wr_en_i && idx_i == IDX_W'(g))     regs_o[g] <= wdata_i & MASK;
    end
  end
endmodule

// File: rtl/mmu_side_fx.sv
module mmu_side_fx
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ASID_W = 8,
  parameter int TI_BIT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  output logic              inval_o,
  output logic              flush_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inval_o <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      inval_o <= wr_en_i && idx_i == REG_MMU_CTL && wdata_i[TI_BIT];
      // compare against the value held before this write lands
      flush_o <= wr_en_i && idx_i == REG_PTE_HI
              && wdata_i[ASID_W-1:0] != cur_asid_i;
    end
  end

  // R9
  no_dual_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(inval_o && flush_o));
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs
  import mmu_regs_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter int ASID_W   = 8,
  parameter int TI_BIT   = 2,
  parameter int ASSIST_W = 4,
  parameter int EVT_W    = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tlb_inval_o,
  output logic              tlb_flush_o,
  output logic              err_o
);
  localparam logic [ADDR_W-1:0] CTL_OFF    = '0;
  localparam logic [ADDR_W-1:0] PTE_HI_OFF = ADDR_W'(4 * int'(REG_PTE_HI));
  localparam logic [ADDR_W-1:0] TRAP_OFF   = ADDR_W'(4 * int'(REG_TRAP_CODE));

  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              wr_en;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rd_val;

  mmu_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .hit_o  (hit),
    .idx_o  (idx)
  );

  assign wr_en = req_i && we_i && hit;

  mmu_reg_bank #(
    .DATA_W(DATA_W), .TI_BIT(TI_BIT), .ASSIST_W(ASSIST_W), .EVT_W(EVT_W)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .idx_i   (idx),
    .wdata_i (wdata_i),
    .regs_o  (regs)
  );

  mmu_side_fx #(.DATA_W(DATA_W), .ASID_W(ASID_W), .TI_BIT(TI_BIT)) u_fx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .idx_i      (idx),
    .wdata_i    (wdata_i),
    .cur_asid_i (regs[int'(REG_PTE_HI)][ASID_W-1:0]),
    .inval_o    (tlb_inval_o),
    .flush_o    (tlb_flush_o)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit && idx == IDX_W'(i)) rd_val = regs[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else if (req_i) begin
      if (!we_i) rdata_o <= rd_val;
      if (!hit)  err_o   <= 1'b1;
    end
  end

  // R6
  ti_reads_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == SZ_WORD && addr_i == CTL_OFF) |=> !rdata_o[TI_BIT]);

  // R5
  trap_narrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i == SZ_WORD && addr_i == TRAP_OFF) |=> rdata_o[DATA_W-1:EVT_W] == '0);

  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  // R8
  bad_size_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && size_i != SZ_WORD) |=> rdata_o == '0);

  // R7
  flush_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_flush_o |-> $past(req_i && we_i && size_i == SZ_WORD && addr_i == PTE_HI_OFF));

  // R6
  inval_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_inval_o |-> $past(req_i && we_i && size_i == SZ_WORD && addr_i == CTL_OFF && wdata_i[TI_BIT]));
endmodule

// File: tb/mmu_ctrl_regs_tb_top.sv
module mmu_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [1:0]  size_i = 2'd2;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tlb_inval_o, tlb_flush_o, err_o;

  mmu_ctrl_regs dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .rdata_o, .tlb_inval_o, .tlb_flush_o, .err_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  logic [31:0] model [9];
  logic [31:0] exp_rdata = '0;
  bit exp_inval = 0, exp_flush = 0, exp_err = 0;
  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("rdata", rdata_o, exp_rdata);
    chk("inval", {31'b0, tlb_inval_o}, {31'b0, exp_inval});
    chk("flush", {31'b0, tlb_flush_o}, {31'b0, exp_flush});
    chk("err",   {31'b0, err_o},       {31'b0, exp_err});
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic idle(string t);
    tag = t; req_i = 0; exp_inval = 0; exp_flush = 0;
    step();
  endtask

  task automatic acc(string t, bit we, logic [7:0] a, logic [1:0] sz, logic [31:0] d);
    bit legal;
    int k;
    tag = t;
    req_i = 1; we_i = we; addr_i = a; size_i = sz; wdata_i = d;
    exp_inval = 0; exp_flush = 0;
    legal = (sz == 2'd2) && (a[1:0] == 2'b00) && (a < 8'h24);
    k = int'(a >> 2);
    if (!legal) begin
      exp_err = 1;
      if (!we) exp_rdata = '0;
    end else if (!we) begin
      exp_rdata = model[k];
    end else begin
      case (k)
        0: begin exp_inval = d[2]; model[0] = d & 32'hFFFF_FFFB; end
        1: begin exp_flush = (d[7:0] != model[1][7:0]); model[1] = d; end
        3: model[3] = d & 32'h0000_000F;
        6, 7, 8: model[k] = d & 32'h0000_07FF;
        default: model[k] = d;
      endcase
    end
    step();
    req_i = 0;
  endtask

  task automatic rd(string t, logic [7:0] a); acc(t, 0, a, 2'd2, '0); endtask
  task automatic wr(string t, logic [7:0] a, logic [31:0] d); acc(t, 1, a, 2'd2, d); endtask

  initial begin
    repeat (2000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 9; i++) model[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    idle("R1");
    for (int i = 0; i < 9; i++) rd("R1", 8'(4 * i));

    // R3 full-width registers
    wr("R3", 8'h08, 32'hDEAD_BEEF);
    wr("R3", 8'h10, 32'hCAFE_F00D);
    wr("R3", 8'h14, 32'h8000_0001);
    rd("R3", 8'h08); rd("R3", 8'h10); rd("R3", 8'h14);
    idle("R2"); idle("R2");

    // R4 assist field
    wr("R4", 8'h0C, 32'hFFFF_FFFF); rd("R4", 8'h0C);
    wr("R4", 8'h0C, 32'h1234_5676); rd("R4", 8'h0C);

    // R5 event fields
    wr("R5", 8'h18, 32'hFFFF_FFFF);
    wr("R5", 8'h1C, 32'h1234_5678);
    wr("R5", 8'h20, 32'h0000_0FFF);
    rd("R5", 8'h18); rd("R5", 8'h1C); rd("R5", 8'h20);

    // R6 invalidate bit
    wr("R6", 8'h00, 32'hFFFF_FFFF); idle("R6"); rd("R6", 8'h00);
    wr("R6", 8'h00, 32'h0000_0001); rd("R6", 8'h00);
    wr("R6", 8'h00, 32'h0000_0004); wr("R6", 8'h00, 32'h0000_0004); rd("R6", 8'h00);

    // R7 identifier change flush
    wr("R7", 8'h04, 32'h0000_00AB); idle("R7");
    wr("R7", 8'h04, 32'hFFFF_00AB); rd("R7", 8'h04);
    wr("R7", 8'h04, 32'hFFFF_00CD); rd("R7", 8'h04);

    // R9 overlap: invalidate, then flush, then read
    wr("R9", 8'h00, 32'h0000_0104);
    wr("R9", 8'h04, 32'h0000_0011);
    rd("R9", 8'h00);
    rd("R9", 8'h04);
    idle("R9");

    // R8 illegal accesses
    acc("R8", 0, 8'h08, 2'd0, '0);
    idle("R8");
    acc("R8", 1, 8'h10, 2'd1, 32'h1111_1111); rd("R8", 8'h10);
    acc("R8", 1, 8'h24, 2'd2, 32'h2222_2222);
    acc("R8", 0, 8'h24, 2'd2, '0);
    acc("R8", 1, 8'h06, 2'd2, 32'h3333_3333); rd("R8", 8'h04);
    acc("R8", 1, 8'h00, 2'd0, 32'hFFFF_FFFF); rd("R8", 8'h00);
    acc("R8", 1, 8'h05, 2'd2, 32'h0000_0099); rd("R8", 8'h04);
    idle("R8"); idle("R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule